// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock with Alarm

This peripheral keeps wall-clock time in seconds. It has a memory-mapped register file written from a fast bus clock. Timekeeping runs on a slow, free-running clock that has no fixed phase relation to the bus clock.

A sub-second prescaler counts slow-clock ticks. Each time it wraps, it advances a 32-bit seconds count. A 32-bit compare value raises a sticky alarm flag, which software clears by writing a one to it. The alarm flag drives an interrupt/wakeup line. A status register reports the alarm and the progress of start-up.

Time does not advance until software completes a two-step start-up handshake. The state machine starts in `ST_INIT`. It moves to `ST_NONVALID` when the init-exit request is set and the key register holds the magic word 0x41736166. It then moves to `ST_VALID` when the init-exit, non-valid-exit and low-power-enable bits are all set. `ST_VALID` is held until reset. Each bus write is first captured on the bus side. It is then carried into the slow domain through a toggle synchronizer and lands on the third slow-clock edge.

Top module: `lp_rtc`

## Requirements
- R1: After reset every register reads zero, the state is `ST_INIT` and `irq_wake` is low.
- R2: A bus write takes effect on the third slow-clock rising edge after the bus edge that captured it, and not earlier.
- R3: The register at 0x10 keeps only bits 3 (low-power enable), 4 (wakeup enable), 7 (alarm interrupt enable), 11 (non-secure access), 14 (non-valid exit request) and 15 (init exit request); all other bits read 0. The register at 0x04 cannot be written.
- R4: `ST_INIT` to `ST_NONVALID` happens one slow edge after the register at 0x10 has bit 15 set while the register at 0x18 equals 0x41736166. The same edge sets status bit 15. With any other key word the block stays in `ST_INIT` and sets no status bit.
- R5: `ST_NONVALID` to `ST_VALID` happens one slow edge after bits 15, 14 and 3 of the register at 0x10 are all set. The same edge sets status bit 14. `ST_VALID` is left only by reset.
- R6: Outside `ST_VALID` neither the sub-second count (read at 0x04) nor the seconds count (read at 0x00) advances.
- R7: In `ST_VALID` the sub-second count rises by one on each slow edge. On wrapping from 2^SUB_W-1 to 0 the seconds count rises by one, and seconds wrap from 0xFFFFFFFF to 0.
- R8: A write to 0x00 loads the seconds count and zeroes the sub-second count in any state. The load takes priority over counting.
- R9: Status bit 3 (alarm pending) is set one slow edge after the seconds count becomes equal to the register at 0x08, in `ST_VALID`. It is set once per period of equality.
- R10: Writing the register at 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged; 0xFFFFFFFF clears them all.
- R11: `irq_wake` is high exactly while alarm pending is set and control bit 7 or control bit 4 is set.
- R12: The register at 0x14 reads alarm pending in bit 3, non-valid-exit done in bit 14 and init-exit done in bit 15, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast register-interface clock |
| slow_clk | input | 1 | Slow timekeeping clock, asynchronous to bus_clk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write strobe, one bus_clk cycle |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from the slow-domain registers |
| irq_wake | output | 1 | Alarm interrupt / wakeup request |

## Verification
A stimulus table drives each register with patterns that tell apart its reserved bits, its read-only behaviour and its reset value. Directed tests follow. One samples the register one edge before and one edge on the third slow edge, which separates a correct synchronizer from one that is too short or too long. The start-up handshake is first run with a wrong key, so that a key check that is missing or ignored shows up, and then with the correct key. The alarm is tried with an alarm match reached by counting and with one reached by a direct load. The interrupt gate is tried with each enable alone and with neither. Counting is checked across a prescaler wrap and across the 32-bit seconds rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ST_INIT     = 2'd0,
        ST_NONVALID = 2'd1,
        ST_VALID    = 2'd2
    } rtc_state_t;

    localparam logic [ADDR_W-1:0] OFS_SEC = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_SUB = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ALM = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STS = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_KEY = 5'h18;

    localparam int C_LP_EN   = 3;
    localparam int C_WAKE_EN = 4;
    localparam int C_ALM_IE  = 7;
    localparam int C_NS_OK   = 11;
    localparam int C_NV_REQ  = 14;
    localparam int C_IN_REQ  = 15;

    localparam int S_ALM     = 3;
    localparam int S_NV_DONE = 14;
    localparam int S_IN_DONE = 15;

    localparam logic [31:0] KEY_WORD = 32'h4173_6166;
    localparam logic [31:0] CTL_MASK = (32'd1 << C_LP_EN) | (32'd1 << C_WAKE_EN)
                                     | (32'd1 << C_ALM_IE) | (32'd1 << C_NS_OK)
                                     | (32'd1 << C_NV_REQ) | (32'd1 << C_IN_REQ);
endpackage

// File: rtl/rtc_wr_cdc.sv
module rtc_wr_cdc #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int STAGES = 3
) (
    input  logic              bus_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              apply_o,
    output logic [ADDR_W-1:0] apply_addr,
    output logic [DATA_W-1:0] apply_data
);
    logic              req_tgl;
    logic [STAGES-1:0] sync_q;

    // bus side: hold the write and flip the request toggle
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl    <= 1'b0;
            apply_addr <= '0;
            apply_data <= '0;
        end else if (wr_en) begin
            req_tgl    <= ~req_tgl;
            apply_addr <= wr_addr;
            apply_data <= wr_data;
        end
    end

    // slow side: toggle chain, a change at its tail marks the apply edge
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], req_tgl};
    end

    assign apply_o = sync_q[STAGES-1] ^ sync_q[STAGES-2];
endmodule

// File: rtl/rtc_fsm.sv
module rtc_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_req,
    input  logic       nv_req,
    input  logic       lp_en,
    input  logic       key_ok,
    output rtc_state_t state_o,
    output logic       in_done_set,
    output logic       nv_done_set,
    output logic       run
);
    rtc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:     if (in_req && key_ok)           state_d = ST_NONVALID;
            ST_NONVALID: if (in_req && nv_req && lp_en)  state_d = ST_VALID;
            ST_VALID:                                    state_d = ST_VALID;
            default:                                     state_d = ST_INIT;
        endcase
    end

    always_comb begin
        state_o     = state_q;
        run         = (state_q == ST_VALID);
        in_done_set = (state_q == ST_INIT)     && (state_d == ST_NONVALID);
        nv_done_set = (state_q == ST_NONVALID) && (state_d == ST_VALID);
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SUB_W-1:0] sub_q,
    output logic [SEC_W-1:0] sec_q
);
    localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            sec_q <= '0;
        end else if (load) begin
            sub_q <= '0;
            sec_q <= load_val;
        end else if (run) begin
            sub_q <= sub_q + 1'b1;
            if (sub_q == SUB_MAX) sec_q <= sec_q + 1'b1;
        end
    end
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
    import rtc_pkg::*;
#(
    parameter int SUB_W  = 15,
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_wake
);
    localparam int SEC_W = DATA_W;

    logic              apply;
    logic [ADDR_W-1:0] ap_addr;
    logic [DATA_W-1:0] ap_data;
    logic [DATA_W-1:0] ctrl_q, key_q, alarm_q;
    logic              sts_alm, sts_nv, sts_in, match_q;
    logic              sec_load, sts_wr, alm_hit;
    logic              in_done_set, nv_done_set, run;
    rtc_state_t        state;
    logic [SUB_W-1:0]  sub_w;
    logic [SEC_W-1:0]  sec_w;

    rtc_wr_cdc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(3)) u_cdc (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .apply_o(apply), .apply_addr(ap_addr), .apply_data(ap_data)
    );

    rtc_fsm u_fsm (
        .clk(slow_clk), .rst_n(rst_n),
        .in_req(ctrl_q[C_IN_REQ]), .nv_req(ctrl_q[C_NV_REQ]),
        .lp_en(ctrl_q[C_LP_EN]), .key_ok(key_q == KEY_WORD),
        .state_o(state), .in_done_set(in_done_set),
        .nv_done_set(nv_done_set), .run(run)
    );

    assign sec_load = apply && (ap_addr == OFS_SEC);
    assign sts_wr   = apply && (ap_addr == OFS_STS);

    rtc_timebase #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_tb (
        .clk(slow_clk), .rst_n(rst_n), .run(run),
        .load(sec_load), .load_val(ap_data),
        .sub_q(sub_w), .sec_q(sec_w)
    );

    // configuration registers in the slow domain
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            key_q   <= '0;
            alarm_q <= '0;
        end else if (apply) begin
            if (ap_addr == OFS_CTL) ctrl_q  <= ap_data & CTL_MASK;
            if (ap_addr == OFS_KEY) key_q   <= ap_data;
            if (ap_addr == OFS_ALM) alarm_q <= ap_data;
        end
    end

    // alarm fires on the first edge of a match period
    assign alm_hit = run && (sec_w == alarm_q) && !match_q;

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_alm <= 1'b0;
            sts_nv  <= 1'b0;
            sts_in  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            match_q <= run && (sec_w == alarm_q);
            if (sts_wr) begin
                if (ap_data[S_ALM])     sts_alm <= 1'b0;
                if (ap_data[S_NV_DONE]) sts_nv  <= 1'b0;
                if (ap_data[S_IN_DONE]) sts_in  <= 1'b0;
            end
            if (alm_hit)     sts_alm <= 1'b1;
            if (nv_done_set) sts_nv  <= 1'b1;
            if (in_done_set) sts_in  <= 1'b1;
        end
    end

    assign irq_wake = sts_alm && (ctrl_q[C_ALM_IE] || ctrl_q[C_WAKE_EN]);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_SEC: rd_data = sec_w;
            OFS_SUB: rd_data[SUB_W-1:0] = sub_w;
            OFS_ALM: rd_data = alarm_q;
            OFS_CTL: rd_data = ctrl_q;
            OFS_STS: begin
                rd_data[S_ALM]     = sts_alm;
                rd_data[S_NV_DONE] = sts_nv;
                rd_data[S_IN_DONE] = sts_in;
            end
            OFS_KEY: rd_data = key_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input rtc_state_t       state,
    input logic [SUB_W-1:0] sub,
    input logic [SEC_W-1:0] sec,
    input logic [SEC_W-1:0] alarm,
    input logic             sec_load,
    input logic             sts_alm,
    input logic             sts_nv,
    input logic             sts_in,
    input logic             irq
);
    localparam logic [SUB_W-1:0] SUB_TOP = {SUB_W{1'b1}};

    assert_irq_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sts_alm);

    assert_hold_before_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_VALID) |-> (sub == '0));

    assert_no_skip_from_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |=> (state != ST_VALID));

    assert_init_done_on_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_in) |-> (state == ST_NONVALID));

    assert_valid_is_terminal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VALID) |=> (state == ST_VALID));

    assert_nv_done_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_nv) |-> (state == ST_VALID));

    assert_prescale_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VALID && sub == SUB_TOP && !sec_load)
        |=> (sub == '0 && sec == $past(sec) + 1'b1));

    assert_alarm_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_alm) |-> ($past(sec) == $past(alarm)));
endmodule

bind lp_rtc rtc_checker #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_chk (
    .clk(slow_clk), .rst_n(rst_n), .state(state), .sub(sub_w), .sec(sec_w),
    .alarm(alarm_q), .sec_load(sec_load), .sts_alm(sts_alm), .sts_nv(sts_nv),
    .sts_in(sts_in), .irq(irq_wake)
);

// File: tb/tb_lp_rtc.sv
`timescale 1ns/100ps
module tb_lp_rtc;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_wake;
    int          n_chk = 0;
    int          n_fail = 0;

    lp_rtc #(.SUB_W(4)) dut (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_wake(irq_wake)
    );

    always #2.5 bus_clk  = ~bus_clk;
    always #23  slow_clk = ~slow_clk;

    // {offset, write data, expected readback}
    localparam logic [31:0] VEC [0:7][0:2] = '{
        '{32'h10, 32'hFFFF_FFFF, 32'h0000_C898},  // R3 reserved control bits
        '{32'h10, 32'h0000_0898, 32'h0000_0898},  // R3
        '{32'h10, 32'h0000_0000, 32'h0000_0000},  // R3
        '{32'h08, 32'h1234_5678, 32'h1234_5678},  // alarm storage
        '{32'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // wrong key word
        '{32'h04, 32'h0000_FFFF, 32'h0000_0000},  // R3 read-only sub-second
        '{32'h14, 32'hFFFF_FFFF, 32'h0000_0000},  // R10/R12
        '{32'h00, 32'h0000_0050, 32'h0000_0050}   // R8 load in ST_INIT
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge slow_clk);
        #1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(posedge slow_clk);
        #1;
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge slow_clk);
        #3 rst_n = 1'b1;
        ticks(1);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reset readback", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq_wake}, 32'h0);

        // R2 timing of one write
        bus_write(5'h08, 32'hA5A5_0001);
        ticks(2);
        rd(5'h08, v); chk("R2 not yet applied after 2 edges", v, 32'h0);
        ticks(1);
        rd(5'h08, v); chk("R2 applied on third edge", v, 32'hA5A5_0001);

        // table walk
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][0][4:0], VEC[i][1]);
            ticks(3);
            rd(VEC[i][0][4:0], v);
            chk("R3 R8 R10 table entry", v, VEC[i][2]);
        end

        // R6 no counting in ST_INIT
        ticks(20);
        rd(5'h00, v); chk("R6 seconds held in init", v, 32'h50);
        rd(5'h04, v); chk("R6 sub-second held in init", v, 32'h0);

        // R4 wrong key blocks the exit
        bus_write(5'h10, 32'h0000_8800);
        ticks(5);
        rd(5'h14, v); chk("R4 wrong key no status", v, 32'h0);
        bus_write(5'h18, 32'h4173_6166);
        ticks(3);
        rd(5'h14, v); chk("R4 status one edge after key", v, 32'h0);
        ticks(1);
        rd(5'h14, v); chk("R4 init exit done", v, 32'h0000_8000);
        ticks(10);
        rd(5'h04, v); chk("R6 sub-second held in non-valid", v, 32'h0);

        // R5 partial request does nothing, full request enters ST_VALID
        bus_write(5'h10, 32'h0000_C800);
        ticks(5);
        rd(5'h14, v); chk("R5 missing low-power enable", v, 32'h0000_8000);
        bus_write(5'h10, 32'h0000_C888);
        ticks(4);
        rd(5'h14, v); chk("R5 non-valid exit done", v, 32'h0000_C000);

        // R7 R8 R9 alarm reached by counting
        bus_write(5'h08, 32'h0000_0202);
        ticks(4);
        bus_write(5'h00, 32'h0000_0200);
        ticks(3);
        rd(5'h04, v); chk("R8 load zeroes sub-second", v, 32'h0);
        rd(5'h00, v); chk("R8 seconds loaded", v, 32'h200);
        ticks(5);
        rd(5'h04, v); chk("R7 sub-second step", v, 32'h5);
        ticks(11);
        rd(5'h04, v); chk("R7 sub-second wraps", v, 32'h0);
        rd(5'h00, v); chk("R7 seconds increment", v, 32'h201);
        ticks(16);
        rd(5'h00, v); chk("R9 seconds at alarm value", v, 32'h202);
        rd(5'h14, v); chk("R9 pending not before next edge", v, 32'h0000_C000);
        ticks(1);
        rd(5'h14, v); chk("R9 R12 pending set", v, 32'h0000_C008);
        chk("R11 irq with alarm interrupt enable", {31'b0, irq_wake}, 32'h1);

        // R10 clear while still matching, must not re-arm
        bus_write(5'h14, 32'h0000_0008);
        ticks(3);
        rd(5'h14, v); chk("R10 pending cleared", v, 32'h0000_C000);
        ticks(4);
        rd(5'h14, v); chk("R9 no re-set in same match", v, 32'h0000_C000);
        chk("R11 irq low after clear", {31'b0, irq_wake}, 32'h0);

        // R9 R11 alarm reached by load, wakeup enable only
        bus_write(5'h10, 32'h0000_C818);
        ticks(4);
        bus_write(5'h08, 32'h0000_0010);
        ticks(4);
        bus_write(5'h00, 32'h0000_0010);
        ticks(4);
        rd(5'h14, v); chk("R9 pending after load match", v, 32'h0000_C008);
        chk("R11 irq with wakeup enable", {31'b0, irq_wake}, 32'h1);
        bus_write(5'h10, 32'h0000_C808);
        ticks(3);
        chk("R11 irq low with both enables off", {31'b0, irq_wake}, 32'h0);
        rd(5'h14, v); chk("R11 pending kept", v, 32'h0000_C008);
        bus_write(5'h14, 32'h0000_0000);
        ticks(3);
        rd(5'h14, v); chk("R10 zero write no effect", v, 32'h0000_C008);
        bus_write(5'h14, 32'hFFFF_FFFF);
        ticks(3);
        rd(5'h14, v); chk("R10 all-ones clears all", v, 32'h0);

        // R7 32-bit rollover, R5 state kept after status clear
        bus_write(5'h00, 32'hFFFF_FFFF);
        ticks(3);
        ticks(15);
        rd(5'h00, v); chk("R7 before rollover", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(5'h00, v); chk("R7 rollover to zero", v, 32'h0);
        rd(5'h04, v); chk("R5 still counting after clear", v, 32'h0);
        ticks(3);
        rd(5'h04, v); chk("R5 counting continues", v, 32'h3);

        summary();
    end
endmodule